// File: doc/BRIEF.md
# MDIO Management Master

This block reads or writes one 16-bit register in an Ethernet PHY over the two-wire management bus. It makes the management clock (MDC) from the system clock and drives the shared data line (MDIO) through three separate signals: a data output, an output enable and a data input. The pad that joins them is placed outside the block.

A request is taken only while the block is idle. It carries a read/write flag, a 5-bit PHY address, a 5-bit register address and the write data. Every frame starts with a full preamble of ones. On a read the master releases the line for the turnaround and checks that the PHY pulls the second turnaround bit low. If the PHY does not, the master drops the read, keeps clocking the bus with the line released so a confused PHY can resynchronise, and reports an error. After the data, the master always adds trailing clock cycles with the line released. Completion is a one-cycle pulse. The read data and the error flag are valid with that pulse and stay unchanged until the next request is accepted.

Bits are counted in MDC periods. One period is `2*DIV` system cycles: `DIV` cycles low, then `DIV` cycles high. Slot numbers below start at 0 for the first preamble bit.

Top module: `mdio_master`

## Requirements
- R1: Slots 0 to 31 of every frame drive MDIO to 1 with the output enable set.
- R2: Slots 32 to 45 drive, MSB first, the 14-bit header: start bits 0,1; opcode 1,0 for a read or 0,1 for a write; then the 5-bit PHY address; then the 5-bit register address.
- R3: MDC is low for exactly DIV system cycles and then high for exactly DIV cycles in every slot. It stays low while the block is idle. The MDIO output and enable change only at the start of a low phase.
- R4: On a read, the output enable is off from slot 46 (first turnaround) to the end of the transaction. MDIO input is sampled at the MDC rising edge of slot 47.
- R5: On a read whose slot-47 sample is 0, MDIO input is sampled at the MDC rising edges of slots 48 to 63. The first sample becomes bit 15 of the read data. The read data is presented with done, and the error flag is 0.
- R6: A successful read has RD_TAIL (default 2) released slots after slot 63. Done goes high exactly (64+RD_TAIL)*2*DIV cycles after the accepting edge, where the accepting edge is cycle 0.
- R7: On a read whose slot-47 sample is 1, the master samples no data and issues RECOV (default 32) more released slots. It then pulses done with the error flag set and the read data 0, exactly (48+RECOV)*2*DIV cycles after acceptance.
- R8: A write drives 1 then 0 in slots 46 and 47, then the 16 data bits MSB first in slots 48 to 63. Slot 64 is released. Done follows 65*2*DIV cycles after acceptance, with the error flag 0.
- R9: A request is accepted only while busy is low. A request raised while busy changes neither the frame in progress nor its timing. Busy is high from the cycle after acceptance until done. Done lasts one cycle, with busy low.
- R10: A request raised in the cycle right after done is accepted, and busy is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_i | input | 5 | PHY address |
| reg_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Turnaround failure on the last read |
| rdata_o | output | 16 | Read data of the last transaction |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data to the pad |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data from the pad |

## Verification
The assertions assume that MDIO input is settled at every system clock edge where MDC rises. They also assume that requests arrive only as plain synchronous pulses. The bench PHY model changes its data only at MDC falling edges. It drives 1 on every slot it does not own, which models a pulled-up idle line. Random requests mix reads and writes, all addresses and data, turnaround failures, and gaps of zero to four cycles between transactions. One directed case raises a second request in the middle of a write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FRAME = 2'd1,
        SQ_RECOV = 2'd2
    } seq_st_e;

    localparam logic [1:0] FR_START = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_o,
    output logic slot_end_o
);
    localparam int PER = 2 * DIV;
    localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i) begin
            cnt_d = (cnt_q == CW'(PER - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // high phase is the upper half of the slot counter
    assign mdc_o      = (cnt_q >= CW'(DIV));
    assign rise_o     = run_i && (cnt_q == CW'(DIV - 1));
    assign slot_end_o = run_i && (cnt_q == CW'(PER - 1));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int RD_TAIL = 2,
    parameter int RECOV   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              mdio_i,
    input  logic              rise_i,
    input  logic              slot_end_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);
    localparam int HW      = 4 + 2 * ADDR_W;
    localparam int HDR_END = PRE_LEN + HW;
    localparam int TA_END  = HDR_END + 2;
    localparam int DAT_END = TA_END + DATA_W;
    localparam int RD_LAST = DAT_END + RD_TAIL - 1;
    localparam int WR_LAST = DAT_END;
    localparam int IW      = $clog2(DAT_END + RD_TAIL + RECOV + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [IW-1:0]     idx;
        logic              rd;
        logic              ta_bad;
        logic              err;
        logic              done;
        logic              oe;
        logic              out;
        logic [HW-1:0]     hdr;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rdat;
    } seq_s;

    seq_s          s_d, s_q;
    logic [HW-1:0] hdr_new;

    // output enable and level for a given slot of the frame
    function automatic logic [1:0] slot_bits(input logic [IW-1:0] i, input logic rd,
                                             input logic [HW-1:0] hdr,
                                             input logic [DATA_W-1:0] wd);
        int                k;
        logic [HW-1:0]     hs;
        logic [DATA_W-1:0] ws;
        k         = int'(i);
        slot_bits = 2'b00;
        if (k < PRE_LEN) begin
            slot_bits = 2'b11;
        end else if (k < HDR_END) begin
            hs        = hdr >> (HDR_END - 1 - k);
            slot_bits = {1'b1, hs[0]};
        end else if (k < TA_END) begin
            if (!rd) slot_bits = {1'b1, (k == HDR_END)};
        end else if (k < DAT_END) begin
            if (!rd) begin
                ws        = wd >> (DAT_END - 1 - k);
                slot_bits = {1'b1, ws[0]};
            end
        end
    endfunction

    assign hdr_new = {FR_START, (rd_i ? OP_READ : OP_WRITE), phy_i, reg_i};

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    s_d.st              = SQ_FRAME;
                    s_d.idx             = '0;
                    s_d.rd              = rd_i;
                    s_d.hdr             = hdr_new;
                    s_d.wd              = wdata_i;
                    s_d.rdat            = '0;
                    s_d.err             = 1'b0;
                    s_d.ta_bad          = 1'b0;
                    {s_d.oe, s_d.out}   = slot_bits('0, rd_i, hdr_new, wdata_i);
                end
            end
            SQ_FRAME: begin
                if (rise_i && s_q.rd) begin
                    if (s_q.idx == IW'(TA_END - 1)) s_d.ta_bad = mdio_i;
                    if (s_q.idx >= IW'(TA_END) && s_q.idx < IW'(DAT_END))
                        s_d.rdat = {s_q.rdat[DATA_W-2:0], mdio_i};
                end
                if (slot_end_i) begin
                    if (s_q.rd && s_q.idx == IW'(TA_END - 1) && s_q.ta_bad) begin
                        s_d.st  = SQ_RECOV;
                        s_d.idx = '0;
                        s_d.oe  = 1'b0;
                        s_d.out = 1'b0;
                    end else if (s_q.idx == (s_q.rd ? IW'(RD_LAST) : IW'(WR_LAST))) begin
                        s_d.st   = SQ_IDLE;
                        s_d.done = 1'b1;
                        s_d.oe   = 1'b0;
                        s_d.out  = 1'b0;
                    end else begin
                        s_d.idx           = s_q.idx + 1'b1;
                        {s_d.oe, s_d.out} = slot_bits(s_q.idx + 1'b1, s_q.rd, s_q.hdr, s_q.wd);
                    end
                end
            end
            SQ_RECOV: begin
                if (slot_end_i) begin
                    if (s_q.idx == IW'(RECOV - 1)) begin
                        s_d.st   = SQ_IDLE;
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o    = (s_q.st != SQ_IDLE);
    assign done_o    = s_q.done;
    assign err_o     = s_q.err;
    assign rdata_o   = s_q.rdat;
    assign mdio_o    = s_q.out;
    assign mdio_oe_o = s_q.oe;
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int DIV     = 4,
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int RD_TAIL = 2,
    parameter int RECOV   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    logic rise, slot_end;

    mdio_mdc_div #(.DIV(DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (busy_o),
        .mdc_o      (mdc_o),
        .rise_o     (rise),
        .slot_end_o (slot_end)
    );

    mdio_frame_seq #(
        .PRE_LEN (PRE_LEN),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RD_TAIL (RD_TAIL),
        .RECOV   (RECOV)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rd_i       (rd_i),
        .phy_i      (phy_i),
        .reg_i      (reg_i),
        .wdata_i    (wdata_i),
        .mdio_i     (mdio_i),
        .rise_i     (rise),
        .slot_end_i (slot_end),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .rdata_o    (rdata_o),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic mdc_o,
    input logic mdio_o,
    input logic mdio_oe_o
);
    logic [15:0] hi_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     hi_cnt_q <= '0;
        else if (mdc_o) hi_cnt_q <= hi_cnt_q + 1'b1;
        else            hi_cnt_q <= '0;
    end

    p_idle_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mdc_o);

    p_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_o |-> $stable({mdio_o, mdio_oe_o}));

    p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc_o) |-> (hi_cnt_q == 16'(DIV)));

    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mdio_oe_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind mdio_master mdio_master_chk #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int DIV     = 4;
    localparam int RD_TAIL = 2;
    localparam int RECOV   = 32;
    localparam int N_WR    = 65;
    localparam int N_RD    = 64 + RD_TAIL;
    localparam int N_ER    = 48 + RECOV;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd = 1'b0, mdio_i = 1'b1;
    logic [4:0]  phy = '0, rga = '0;
    logic [15:0] wd = '0;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;

    always #4 clk = ~clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_i(rd), .phy_i(phy), .reg_i(rga),
        .wdata_i(wd), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
        .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // slot monitor: what the master presents at each MDC rise
    logic        mon_oe [0:127];
    logic        mon_v  [0:127];
    int          mon_n = 0;
    logic [15:0] sl_data = '0;
    logic        sl_ta = 1'b0;

    always @(posedge mdc) begin
        if (mon_n < 128) begin
            mon_oe[mon_n] = mdio_oe;
            mon_v[mon_n]  = mdio_o;
        end
        mon_n++;
    end

    // PHY model: changes the line after MDC falls, 1 when not owning it
    always @(negedge mdc) begin
        if (mon_n == 47)                     mdio_i = sl_ta;
        else if (mon_n >= 48 && mon_n < 64)  mdio_i = sl_data[63-mon_n];
        else                                 mdio_i = 1'b1;
    end

    // MDC phase widths and output stability during high phase
    int   hi_run = 0, lo_run = 0, phase_bad = 0;
    logic prev_mdc = 1'b0;
    logic [1:0] prev_out = 2'b00;
    always @(negedge clk) begin
        if (mdc) begin
            if (!prev_mdc && lo_run != DIV) phase_bad++;
            if (prev_mdc && {mdio_oe, mdio_o} != prev_out) phase_bad++;
            lo_run = 0;
            hi_run++;
        end else begin
            if (prev_mdc && hi_run != DIV) phase_bad++;
            hi_run = 0;
            if (busy) lo_run++;
            else      lo_run = 0;
        end
        prev_mdc = mdc;
        prev_out = {mdio_oe, mdio_o};
    end

    int done_cnt = 0;
    always @(posedge clk) if (done) done_cnt++;

    // expected {oe, level} for slot i
    function automatic logic [1:0] exp_slot(int i, bit r, logic [4:0] p, logic [4:0] g,
                                            logic [15:0] w);
        logic [13:0] h;
        h = {2'b01, (r ? 2'b10 : 2'b01), p, g};
        if (i < 32) return 2'b11;
        if (i < 46) return {1'b1, h[45-i]};
        if (i < 48) return r ? 2'b00 : {1'b1, (i == 46)};
        if (i < 64) return r ? 2'b00 : {1'b1, w[63-i]};
        return 2'b00;
    endfunction

    task automatic check_range(int lo, int hi, bit r, logic [4:0] p, logic [4:0] g,
                               logic [15:0] w, string req, string what);
        int bad = 0, act = 0, exp = 0;
        for (int i = lo; i <= hi; i++) begin
            logic [1:0] e, got;
            e   = exp_slot(i, r, p, g, w);
            got = {mon_oe[i], mon_v[i]};
            if (e[1] ? (got != e) : got[1]) begin
                if (bad == 0) begin act = {i, 6'h0, got}; exp = {i, 6'h0, e}; end
                bad++;
            end
        end
        chk(bad == 0, req, what, act, exp);
    endtask

    task automatic run_txn(input bit r, input logic [4:0] p, input logic [4:0] g,
                           input logic [15:0] w, input logic [15:0] pd, input bit ta,
                           input bit poke, input bit b2b);
        int lat = 0, busy_gap = 0, n_exp, cnt0;
        @(negedge clk);
        mon_n = 0; phase_bad = 0; sl_data = pd; sl_ta = ta; cnt0 = done_cnt;
        start = 1'b1; rd = r; phy = p; rga = g; wd = w;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, b2b ? "R10" : "R9", "busy after accept", busy, 1);
        forever begin
            if (poke && lat == 100) begin
                start = 1'b1; rd = ~r; phy = ~p; rga = ~g; wd = ~w;
            end
            if (poke && lat == 102) start = 1'b0;
            if (done || lat > 5000) break;
            if (!busy) busy_gap++;
            @(negedge clk);
            lat++;
        end
        n_exp = r ? (ta ? N_ER : N_RD) : N_WR;
        chk(lat == n_exp * 2 * DIV, r ? (ta ? "R7" : "R6") : "R8", "latency", lat, n_exp * 2 * DIV);
        chk(mon_n == n_exp, r ? (ta ? "R7" : "R6") : "R8", "slot count", mon_n, n_exp);
        check_range(0, 31, r, p, g, w, "R1", "preamble");
        check_range(32, 45, r, p, g, w, "R2", "header");
        if (r) check_range(46, n_exp - 1, r, p, g, w, ta ? "R7" : "R4", "released line");
        else   check_range(46, n_exp - 1, r, p, g, w, "R8", "turnaround/data/tail");
        chk(phase_bad == 0, "R3", "mdc phase shape", phase_bad, 0);
        chk(busy_gap == 0 && !busy, "R9", "busy span", busy_gap, 0);
        chk(done_cnt == cnt0, "R9", "single done", done_cnt - cnt0, 0);
        if (r && ta) begin
            chk(err == 1'b1 && rdata == 16'h0, "R7", "error result", {err, rdata}, 32'h10000);
        end else if (r) begin
            chk(err == 1'b0 && rdata == pd, "R5", "read data", {err, rdata}, {1'b0, pd});
        end else begin
            chk(err == 1'b0, "R8", "write error flag", err, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R9", "reset handshake", {busy, done, err}, 0);
        chk(!mdc && !mdio_oe && rdata == 0, "R3", "reset bus idle", {mdc, mdio_oe}, 0);

        run_txn(1'b0, 5'h1f, 5'h00, 16'h8001, 16'h0000, 1'b0, 1'b0, 1'b0);
        run_txn(1'b1, 5'h00, 5'h1f, 16'h0000, 16'ha5c3, 1'b0, 1'b0, 1'b0);
        run_txn(1'b1, 5'h0a, 5'h15, 16'h0000, 16'hffff, 1'b1, 1'b0, 1'b0);
        run_txn(1'b0, 5'h11, 5'h02, 16'h1234, 16'h0000, 1'b0, 1'b1, 1'b0);
        run_txn(1'b1, 5'h03, 5'h04, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1);
        run_txn(1'b1, 5'h15, 5'h0a, 16'h0000, 16'h8000, 1'b0, 1'b0, 1'b1);

        for (int t = 0; t < 10; t++) begin
            bit r, bad, b2b;
            r   = 1'($urandom % 2);
            bad = r && ($urandom % 5 == 0);
            b2b = 1'($urandom % 2);
            if (!b2b) repeat (1 + $urandom % 4) @(negedge clk);
            run_txn(r, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), bad, 1'b0, b2b);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule